// File: doc/BRIEF.md
# Independent Watchdog Timer with Key-Protected Control

This block is a watchdog that keeps time on its own low-speed clock, apart from the system clock. A 12-bit down counter is clocked by a power-of-two prescaler that divides the low-speed clock by 4 to 256. When the counter runs out, the block pulses a reset request for one low-speed cycle. It then reloads itself and keeps counting. It has no interrupt, and the reset request is its only action.

Software controls the block through one write channel on the system clock. Each write carries a target select and 16 bits of data. Magic values written to the key target start the timer, refresh it, or unlock the prescaler and reload targets. Each write crosses into the watchdog clock domain through a toggle handshake. The channel is valid/ready. A write is taken on a system clock edge where `wr_valid` and `wr_ready` are both high. After that, `wr_ready` stays low until the write has been applied in the watchdog domain. While `wr_valid` is high and `wr_ready` is low, the source must hold `wr_valid`, `wr_sel` and `wr_data` steady.

A strap input sampled just after reset can start the timer with no key write. Nothing short of a reset stops the timer once it runs.

Top module: `indep_watchdog`

## Requirements
- R1: After reset in software mode (strap low), no reset request is produced until a key write of 0xCCCC. After that key write the timer runs.
- R2: A key write of 0xAAAA copies the reload register into the counter and restarts the prescaler. If refreshes arrive more often than the timeout, no reset request is produced. Once refreshes stop, a request follows one timeout later.
- R3: While running, consecutive reset requests are exactly (reload + 1) × divisor low-speed cycles apart.
- R4: The prescaler code is taken from data bits [2:0] of a write with `wr_sel` = 1. Codes 0 to 6 select divisor 4 << code. Code 7 selects 256.
- R5: The reload value is taken from data bits [11:0] of a write with `wr_sel` = 2. A reload of 0 gives one prescaled tick per timeout.
- R6: Prescaler and reload writes are ignored unless the last key write was 0x5555. The block is locked after reset.
- R7: Any key write other than 0x5555, including 0xAAAA and 0xCCCC, locks the configuration again.
- R8: The reset request is high for exactly one low-speed cycle. After it fires, the counter reloads and keeps running.
- R9: If `hw_start_strap` is high at reset release, the timer runs with no key write. No key value ever stops a running timer.
- R10: After reset, `rst_req` is low and `wr_ready` is high. The prescaler code is 0 and the reload value is 0xFFF, so a strap start fires first about 16384 low-speed cycles after reset.
- R11: `wr_sel` encoding: 0 = key, 1 = prescaler, 2 = reload, 3 = no effect. After a write is accepted, `wr_ready` is low until that write has been applied in the watchdog domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the write channel |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Channel can take a write |
| wr_sel | input | 2 | Write target: 0 key, 1 prescaler, 2 reload, 3 none |
| wr_data | input | 16 | Write payload |
| wdg_clk | input | 1 | Dedicated low-speed clock |
| wdg_rst_n | input | 1 | Asynchronous active-low reset, watchdog domain |
| hw_start_strap | input | 1 | Start the timer at reset without software |
| rst_req | output | 1 | One-cycle reset request, watchdog domain |

## Verification
The assertions assume the write source follows the channel rules: once it raises `wr_valid`, it holds the payload and `wr_valid` until the write is accepted. They also assume both domain resets are applied together, and that the strap is steady around reset release. The stimulus meets these rules by raising `wr_valid` only when `wr_ready` is already high and dropping it right after the accepting edge. Every write waits for `wr_ready` to return before the next one starts, so each command has reached the watchdog domain before the bench measures its effect. Timing is checked as the spacing between two reset requests, so the variable handshake latency does not enter the expected values.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;

  localparam int KEY_W = 16;

  // write target select
  typedef enum logic [1:0] {
    SEL_KEY    = 2'd0,
    SEL_PRESC  = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;

  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;

  typedef struct packed {
    logic [1:0]       sel;
    logic [KEY_W-1:0] data;
  } wr_beat_t;

endpackage

// File: rtl/wdg_hs_cdc.sv
`timescale 1ns/1ps
// Toggle handshake carrying one held beat from the source to the destination domain.
module wdg_hs_cdc #(
  parameter int W     = 18,
  parameter int SYNC  = 2
) (
  input  logic         s_clk,
  input  logic         s_rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  input  logic         d_clk,
  input  logic         d_rst_n,
  output logic         d_pulse,
  output logic [W-1:0] d_data
);

  logic            req_t;
  logic [W-1:0]    hold_q;
  logic [SYNC-1:0] ack_sync;
  logic [SYNC-1:0] req_sync;
  logic            ack_t;

  // source side: capture the beat and flip the request
  assign s_ready = (ack_sync[SYNC-1] == req_t);

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      req_t  <= 1'b0;
      hold_q <= '0;
    end else if (s_valid && s_ready) begin
      req_t  <= ~req_t;
      hold_q <= s_data;
    end
  end

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) ack_sync <= '0;
    else          ack_sync <= {ack_sync[SYNC-2:0], ack_t};
  end

  // destination side: a mismatch marks a new beat, acknowledged at once
  always_ff @(posedge d_clk or negedge d_rst_n) begin
    if (!d_rst_n) req_sync <= '0;
    else          req_sync <= {req_sync[SYNC-2:0], req_t};
  end

  assign d_pulse = (req_sync[SYNC-1] != ack_t);
  assign d_data  = hold_q;

  always_ff @(posedge d_clk or negedge d_rst_n) begin
    if (!d_rst_n)     ack_t <= 1'b0;
    else if (d_pulse) ack_t <= ~ack_t;
  end

endmodule

// File: rtl/wdg_key_ctrl.sv
`timescale 1ns/1ps
// Key decoder, configuration lock, run flag and the two protected registers.
module wdg_key_ctrl
  import wdg_pkg::*;
#(
  parameter int              CNT_W   = 12,
  parameter int              PRE_W   = 3,
  parameter logic [CNT_W-1:0] RLD_RST = '1,
  parameter logic [PRE_W-1:0] PRE_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_pulse,
  input  wr_beat_t         cmd_beat,
  input  logic             hw_start_strap,
  output logic             run,
  output logic             refresh,
  output logic             unlocked,
  output logic [PRE_W-1:0] pre_code,
  output logic [CNT_W-1:0] reload_val
);

  logic boot_q;
  logic key_hit, presc_hit, rld_hit;
  logic is_start, is_open, is_refresh;

  assign key_hit    = cmd_pulse && (cmd_beat.sel == SEL_KEY);
  assign presc_hit  = cmd_pulse && (cmd_beat.sel == SEL_PRESC);
  assign rld_hit    = cmd_pulse && (cmd_beat.sel == SEL_RELOAD);
  assign is_start   = (cmd_beat.data == KEY_START);
  assign is_open    = (cmd_beat.data == KEY_OPEN);
  assign is_refresh = (cmd_beat.data == KEY_REFRESH);

  assign refresh = key_hit && is_refresh;

  // run flag: set by strap once after reset or by the start key, never cleared
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      run    <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      if ((boot_q && hw_start_strap) || (key_hit && is_start))
        run <= 1'b1;
    end
  end

  // lock: every key write decides, only the open key leaves it open
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       unlocked <= 1'b0;
    else if (key_hit) unlocked <= is_open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_code   <= PRE_RST;
      reload_val <= RLD_RST;
    end else begin
      if (presc_hit && unlocked) pre_code   <= cmd_beat.data[PRE_W-1:0];
      if (rld_hit && unlocked)   reload_val <= cmd_beat.data[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/wdg_timebase.sv
`timescale 1ns/1ps
// Power-of-two prescaler feeding the down counter and the reset request.
module wdg_timebase #(
  parameter int               CNT_W        = 12,
  parameter int               PRE_W        = 3,
  parameter int               DIV_MIN_LOG2 = 2,
  parameter int               DIV_MAX_LOG2 = 8,
  parameter logic [CNT_W-1:0] RLD_RST      = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             refresh,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [CNT_W-1:0] reload_val,
  output logic             rst_req
);

  localparam int PC_W  = DIV_MAX_LOG2;
  localparam int NCODE = 1 << PRE_W;

  logic [PC_W-1:0]  lim_tab [NCODE];
  logic [PC_W-1:0]  lim;
  logic [PC_W-1:0]  pc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  // terminal prescaler count per code, saturating at the largest divisor
  for (genvar g = 0; g < NCODE; g++) begin : g_lim
    localparam int SH = ((DIV_MIN_LOG2 + g) > DIV_MAX_LOG2) ? DIV_MAX_LOG2 : (DIV_MIN_LOG2 + g);
    assign lim_tab[g] = PC_W'((1 << SH) - 1);
  end

  assign lim  = lim_tab[pre_code];
  assign tick = run && (pc_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      cnt_q   <= RLD_RST;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (refresh) begin
        pc_q  <= '0;
        cnt_q <= reload_val;
      end else if (run) begin
        if (tick) begin
          pc_q <= '0;
          if (cnt_q == '0) begin
            cnt_q   <= reload_val;
            rst_req <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end else begin
          pc_q <= pc_q + PC_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/indep_watchdog.sv
`timescale 1ns/1ps
module indep_watchdog
  import wdg_pkg::*;
#(
  parameter int               CNT_W        = 12,
  parameter int               PRE_W        = 3,
  parameter int               DIV_MIN_LOG2 = 2,
  parameter int               DIV_MAX_LOG2 = 8,
  parameter int               SYNC_STAGES  = 2,
  parameter logic [CNT_W-1:0] RLD_RST      = '1
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [1:0]       wr_sel,
  input  logic [KEY_W-1:0] wr_data,
  input  logic             wdg_clk,
  input  logic             wdg_rst_n,
  input  logic             hw_start_strap,
  output logic             rst_req
);

  localparam int BEAT_W = $bits(wr_beat_t);

  wr_beat_t         src_beat;
  wr_beat_t         cmd_beat;
  logic [BEAT_W-1:0] cmd_bits;
  logic             cmd_pulse;
  logic             run;
  logic             refresh;
  logic             unlocked;
  logic [PRE_W-1:0] pre_code;
  logic [CNT_W-1:0] reload_val;

  assign src_beat.sel  = wr_sel;
  assign src_beat.data = wr_data;
  assign cmd_beat      = wr_beat_t'(cmd_bits);

  wdg_hs_cdc #(.W(BEAT_W), .SYNC(SYNC_STAGES)) u_cdc (
    .s_clk   (sys_clk),
    .s_rst_n (sys_rst_n),
    .s_valid (wr_valid),
    .s_ready (wr_ready),
    .s_data  (src_beat),
    .d_clk   (wdg_clk),
    .d_rst_n (wdg_rst_n),
    .d_pulse (cmd_pulse),
    .d_data  (cmd_bits)
  );

  wdg_key_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .RLD_RST(RLD_RST), .PRE_RST('0)) u_ctrl (
    .clk            (wdg_clk),
    .rst_n          (wdg_rst_n),
    .cmd_pulse      (cmd_pulse),
    .cmd_beat       (cmd_beat),
    .hw_start_strap (hw_start_strap),
    .run            (run),
    .refresh        (refresh),
    .unlocked       (unlocked),
    .pre_code       (pre_code),
    .reload_val     (reload_val)
  );

  wdg_timebase #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .DIV_MIN_LOG2(DIV_MIN_LOG2),
    .DIV_MAX_LOG2(DIV_MAX_LOG2), .RLD_RST(RLD_RST)
  ) u_tb (
    .clk        (wdg_clk),
    .rst_n      (wdg_rst_n),
    .run        (run),
    .refresh    (refresh),
    .pre_code   (pre_code),
    .reload_val (reload_val),
    .rst_req    (rst_req)
  );

endmodule

// File: rtl/wdg_checker.sv
`timescale 1ns/1ps
module wdg_checker #(
  parameter int CNT_W = 12,
  parameter int PRE_W = 3
) (
  input logic             sys_clk,
  input logic             sys_rst_n,
  input logic             wdg_clk,
  input logic             wdg_rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [1:0]       wr_sel,
  input logic [15:0]      wr_data,
  input logic             rst_req,
  input logic             run,
  input logic             unlocked,
  input logic [PRE_W-1:0] pre_code,
  input logic [CNT_W-1:0] reload_val
);

  // R8: request lasts a single watchdog cycle
  p_req_single_r8: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
    rst_req |=> !rst_req);

  // R1: a stopped timer never requests a reset
  p_quiet_idle_r1: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
    !run |-> !rst_req);

  // R9: once running, nothing stops it
  p_run_sticky_r9: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
    run |=> run);

  // R6: locked configuration does not change
  p_lock_hold_r6: assert property (@(posedge wdg_clk) disable iff (!wdg_rst_n)
    !unlocked |=> ($stable(pre_code) && $stable(reload_val)));

  // R11: ready drops after an accepted write
  p_accept_busy_r11: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);

  // R11: the source keeps its payload while stalled
  p_hold_payload_r11: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_sel) && $stable(wr_data)));

endmodule

bind indep_watchdog wdg_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) chk_i (
  .sys_clk    (sys_clk),
  .sys_rst_n  (sys_rst_n),
  .wdg_clk    (wdg_clk),
  .wdg_rst_n  (wdg_rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .rst_req    (rst_req),
  .run        (run),
  .unlocked   (unlocked),
  .pre_code   (pre_code),
  .reload_val (reload_val)
);

// File: tb/indep_watchdog_tb_top.sv
`timescale 1ns/1ps
module indep_watchdog_tb_top;
  import wdg_pkg::*;

  logic        sys_clk = 1'b0;
  logic        wdg_clk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        wdg_rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        hw_start_strap = 1'b0;
  logic        wr_ready;
  logic        rst_req;

  always #4  sys_clk = ~sys_clk;
  always #10 wdg_clk = ~wdg_clk;

  indep_watchdog dut_i (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .wdg_clk(wdg_clk), .wdg_rst_n(wdg_rst_n),
    .hw_start_strap(hw_start_strap), .rst_req(rst_req)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int slow_cyc = 0;
  int pulse_cnt = 0;
  int last_stamp = 0;
  int prev_stamp = 0;
  int wide_err = 0;
  bit prev_hi = 1'b0;
  bit last_busy = 1'b0;

  // {prescaler code, reload, expected spacing in slow cycles}: R3 R4 R5
  localparam int NVEC = 9;
  localparam logic [47:0] VEC [NVEC] = '{
    {16'd0, 16'd9,  16'd40},
    {16'd3, 16'd4,  16'd160},
    {16'd5, 16'd2,  16'd384},
    {16'd6, 16'd1,  16'd512},
    {16'd7, 16'd1,  16'd512},
    {16'd1, 16'd0,  16'd8},
    {16'd0, 16'd0,  16'd4},
    {16'd2, 16'd15, 16'd256},
    {16'd4, 16'd3,  16'd256}
  };

  always @(negedge wdg_clk) begin
    slow_cyc = slow_cyc + 1;
    if (rst_req === 1'b1) begin
      pulse_cnt  = pulse_cnt + 1;
      prev_stamp = last_stamp;
      last_stamp = slow_cyc;
      if (prev_hi) wide_err = wide_err + 1;
    end
    prev_hi = (rst_req === 1'b1);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap, output int rel);
    sys_rst_n = 1'b0;
    wdg_rst_n = 1'b0;
    wr_valid = 1'b0;
    hw_start_strap = strap;
    repeat (4) @(negedge wdg_clk);
    @(negedge sys_clk);
    sys_rst_n = 1'b1;
    wdg_rst_n = 1'b1;
    rel = slow_cyc;
  endtask

  task automatic bus_wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge sys_clk);
    while (wr_ready !== 1'b1) @(negedge sys_clk);
    wr_valid = 1'b1;
    wr_sel = sel;
    wr_data = data;
    @(negedge sys_clk);
    wr_valid = 1'b0;
    last_busy = (wr_ready === 1'b0);
    while (wr_ready !== 1'b1) @(negedge sys_clk);
  endtask

  task automatic wait_pulse(input int limit, output bit got);
    int start;
    start = pulse_cnt;
    got = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(posedge wdg_clk);
      if (pulse_cnt != start) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic measure(input int exp, input string tag);
    bit g1, g2;
    wait_pulse(exp * 2 + 50, g1);
    wait_pulse(exp + 50, g2);
    check(g1 && g2 && (last_stamp - prev_stamp == exp), tag, last_stamp - prev_stamp, exp);
  endtask

  initial begin
    repeat (190000) @(posedge sys_clk);
    if (!done) begin
      errors = errors + 1;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rs;
    bit got;
    int base;

    // reset state (R10)
    do_reset(1'b0, rs);
    @(negedge sys_clk);
    check(rst_req === 1'b0, "R10 rst_req after reset", int'(rst_req), 0);
    check(wr_ready === 1'b1, "R10 wr_ready after reset", int'(wr_ready), 1);

    // R1: configured and refreshed but not started
    bus_wr(SEL_KEY, KEY_OPEN);
    bus_wr(SEL_PRESC, 16'd0);
    bus_wr(SEL_RELOAD, 16'd9);
    bus_wr(SEL_KEY, KEY_REFRESH);
    check(last_busy, "R11 ready low after accept", int'(last_busy), 1);
    wait_pulse(300, got);
    check(!got, "R1 no request before start key", int'(got), 0);
    bus_wr(SEL_KEY, KEY_START);
    measure(40, "R1 R3 running after start key");

    // vector table: R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      bus_wr(SEL_KEY, KEY_OPEN);
      bus_wr(SEL_PRESC, VEC[v][47:32]);
      bus_wr(SEL_RELOAD, VEC[v][31:16]);
      bus_wr(SEL_KEY, KEY_REFRESH);
      measure(int'(VEC[v][15:0]), $sformatf("R3 R4 R5 vector %0d", v));
    end
    check(wide_err == 0, "R8 request width one cycle", wide_err, 0);

    // R6: locked writes ignored (last config: code 4, reload 3 -> 256)
    bus_wr(SEL_RELOAD, 16'd0);
    bus_wr(SEL_PRESC, 16'd0);
    bus_wr(SEL_KEY, KEY_REFRESH);
    measure(256, "R6 locked writes ignored");

    // R7: another key relocks
    bus_wr(SEL_KEY, KEY_OPEN);
    bus_wr(SEL_KEY, 16'h1234);
    bus_wr(SEL_RELOAD, 16'd0);
    bus_wr(SEL_KEY, KEY_REFRESH);
    measure(256, "R7 odd key relocks");
    bus_wr(SEL_KEY, KEY_OPEN);
    bus_wr(SEL_KEY, KEY_REFRESH);
    bus_wr(SEL_RELOAD, 16'd0);
    bus_wr(SEL_KEY, KEY_REFRESH);
    measure(256, "R7 refresh key relocks");

    // R2: steady refresh holds off the request
    bus_wr(SEL_KEY, KEY_OPEN);
    bus_wr(SEL_PRESC, 16'd0);
    bus_wr(SEL_RELOAD, 16'd49);
    bus_wr(SEL_KEY, KEY_REFRESH);
    base = pulse_cnt;
    for (int k = 0; k < 30; k++) begin
      bus_wr(SEL_KEY, KEY_REFRESH);
      repeat (20) @(negedge sys_clk);
    end
    check(pulse_cnt == base, "R2 refresh prevents request", pulse_cnt - base, 0);
    wait_pulse(260, got);
    check(got, "R2 request after refresh stops", int'(got), 1);

    // R11: select 3 has no effect (not taken as an open key)
    bus_wr(2'd3, KEY_OPEN);
    bus_wr(SEL_RELOAD, 16'd7);
    bus_wr(SEL_KEY, KEY_REFRESH);
    measure(200, "R11 select 3 ignored");
    check(wide_err == 0, "R8 request width after reloads", wide_err, 0);

    // R9 R10: strap start with reset defaults
    do_reset(1'b1, rs);
    bus_wr(SEL_RELOAD, 16'd5);
    wait_pulse(17500, got);
    check(got && (last_stamp - rs >= 16380) && (last_stamp - rs <= 16392),
          "R9 R10 strap start default timeout", last_stamp - rs, 16385);
    wait_pulse(1000, got);
    check(!got, "R6 locked from reset", int'(got), 0);
    bus_wr(SEL_KEY, KEY_OPEN);
    bus_wr(SEL_RELOAD, 16'd5);
    bus_wr(SEL_KEY, KEY_REFRESH);
    measure(24, "R9 strap running without start key");
    bus_wr(SEL_KEY, 16'h0000);
    bus_wr(SEL_KEY, 16'h1234);
    bus_wr(SEL_KEY, 16'hFFFF);
    measure(24, "R9 no key stops the timer");
    check(wide_err == 0, "R8 request width in strap mode", wide_err, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule